// File: doc/BRIEF.md
# PWM Compare and Action Stage

This block sits after a PWM time-base counter and turns the counter value into a raw PWM waveform. On every clock it compares the counter against an active compare value. It also watches a zero strobe that marks the start of each period. Three events can change the output: the counter reaching zero, a compare match while counting up, and a compare match while counting down. Each event carries a 2-bit action code that sets, clears or toggles the output, or leaves it alone. The registered output feeds a dead-band stage further down.

The compare value is double-buffered. In shadow mode a host write lands in a shadow register, and the shadow moves into the active register only on a chosen load event. This lets software change the duty cycle in mid-period without producing a glitch. In immediate mode a write goes straight to the active register. For example, with a zero action of set, a compare-up action of clear, a compare of 600 and a period of 1200, the output is high for 600 of 1201 counts, which is about 50% duty.

Top module: `pwm_cmp_aq`

## Requirements
- R1: After reset `pwm_raw` is 0 and the active compare value is 0.
- R2: When `shadow_en` is 0, a write on `cmp_wr` updates the active compare value, and it is used from the next cycle on.
- R3: When `shadow_en` is 1, a write changes only the shadow value. The active compare value is kept until the next load event.
- R4: With `load_sel` = 0, the shadow value moves to the active register in the cycle where `cnt_zero` is high. A compare in that same cycle still uses the old value.
- R5: With `load_sel` = 1, the shadow value also moves to the active register on a compare-up match. That match is judged against the old value.
- R6: Action codes are 2'b00 no change, 2'b01 drive low, 2'b10 drive high, 2'b11 invert. `pwm_raw` shows the result one clock after the event.
- R7: A cycle with `cnt_zero` high applies `act_zero`. The toggle code inverts the output on every such cycle.
- R8: When `cnt` equals the active compare value, `act_cmp_up` applies if `cnt_up` is 1, and `act_cmp_dn` applies if `cnt_up` is 0.
- R9: When `cnt_zero` and a compare match happen in the same cycle, only `act_zero` is applied.
- R10: In a cycle with no event, `pwm_raw` keeps its value.
- R11: With zero = set, compare-up = clear, a period of 1200 and a compare of 600, `pwm_raw` is high for exactly 600 of the 1201 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CW | Time-base counter value |
| cnt_zero | input | 1 | Counter-equals-zero strobe |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| cmp_wr | input | 1 | Host write strobe for the compare value |
| cmp_wdata | input | CW | Host compare write data |
| shadow_en | input | 1 | 1 = writes go to the shadow register, 0 = writes go to the active register |
| load_sel | input | 1 | Load event: 0 = zero only, 1 = zero or compare-up match |
| act_zero | input | 2 | Action code for the zero event |
| act_cmp_up | input | 2 | Action code for a compare match while counting up |
| act_cmp_dn | input | 2 | Action code for a compare match while counting down |
| pwm_raw | output | 1 | Registered raw PWM output |

## Verification
A wrong active or shadow compare value has no port of its own. It shows up as a compare edge that lands at the wrong count: in the same period for an immediate write, or one period late or early when a shadow load is mistimed. The bench therefore counts high cycles per period against periods it computes itself. A wrong action decode or wrong event priority appears on `pwm_raw` one clock after the offending event. A lost hold shows as a change in a cycle that has no event.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  typedef enum logic [1:0] {
    AQ_NONE = 2'b00,
    AQ_CLR  = 2'b01,
    AQ_SET  = 2'b10,
    AQ_TOG  = 2'b11
  } aq_act_e;

  typedef enum logic {
    LD_ZERO     = 1'b0,
    LD_ZERO_CMP = 1'b1
  } ld_sel_e;

  function automatic logic aq_apply(input aq_act_e act, input logic cur);
    case (act)
      AQ_CLR:  return 1'b0;
      AQ_SET:  return 1'b1;
      AQ_TOG:  return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          shadow_en,
  input  logic          load_evt,
  output logic [CW-1:0] active
);
  logic [CW-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active   <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (!shadow_en) begin
        if (wr) active <= wdata;
      end else if (load_evt) begin
        active <= shadow_q;
      end
    end
  end

  // R2: immediate write is active next cycle
  a_r2_immediate_write: assert property (@(posedge clk) disable iff (rst)
    (!shadow_en && wr) |=> (active == $past(wdata)));
  // R3: shadow mode holds active value between load events
  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (shadow_en && !load_evt) |=> $stable(active));
  // R4: load event transfers the previously held shadow value
  a_r4_shadow_load: assert property (@(posedge clk) disable iff (rst)
    (shadow_en && load_evt) |=> (active == $past(shadow_q)));
endmodule

// File: rtl/pwm_aq_events.sv
module pwm_aq_events #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] active,
  input  logic          cnt_zero,
  input  logic          cnt_up,
  input  logic          load_sel,
  output logic          ev_up,
  output logic          ev_dn,
  output logic          load_evt
);
  import pwm_aq_pkg::*;

  logic hit;

  always_comb begin
    hit   = (cnt == active);
    ev_up = hit && cnt_up;
    ev_dn = hit && !cnt_up;
    if (ld_sel_e'(load_sel) == LD_ZERO_CMP) load_evt = cnt_zero || ev_up;
    else                                    load_evt = cnt_zero;
  end

  // R8: a compare match is never both directions
  a_r8_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ev_up && ev_dn));
  // R4: zero strobe always yields a load event
  a_r4_zero_loads: assert property (@(posedge clk) disable iff (rst)
    cnt_zero |-> load_evt);
endmodule

// File: rtl/pwm_aq_output.sv
module pwm_aq_output (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_zero,
  input  logic       ev_up,
  input  logic       ev_dn,
  input  logic [1:0] act_zero,
  input  logic [1:0] act_cmp_up,
  input  logic [1:0] act_cmp_dn,
  output logic       pwm
);
  import pwm_aq_pkg::*;

  logic pwm_nxt;

  always_comb begin
    pwm_nxt = pwm;
    if (cnt_zero)   pwm_nxt = aq_apply(aq_act_e'(act_zero), pwm);
    else if (ev_up) pwm_nxt = aq_apply(aq_act_e'(act_cmp_up), pwm);
    else if (ev_dn) pwm_nxt = aq_apply(aq_act_e'(act_cmp_dn), pwm);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= pwm_nxt;
  end

  // R9: zero set wins regardless of compare
  a_r9_zero_set_wins: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero && act_zero == 2'b10) |=> pwm);
  // R7: toggle on zero inverts output
  a_r7_zero_toggle: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero && act_zero == 2'b11) |=> (pwm != $past(pwm)));
  // R10: no event keeps output
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_zero && !ev_up && !ev_dn) |=> $stable(pwm));
  // R6: clear code on an up match drives low
  a_r6_up_clear: assert property (@(posedge clk) disable iff (rst)
    (!cnt_zero && ev_up && act_cmp_up == 2'b01) |=> !pwm);
endmodule

// File: rtl/pwm_cmp_aq.sv
module pwm_cmp_aq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_zero,
  input  logic          cnt_up,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          shadow_en,
  input  logic          load_sel,
  input  logic [1:0]    act_zero,
  input  logic [1:0]    act_cmp_up,
  input  logic [1:0]    act_cmp_dn,
  output logic          pwm_raw
);
  logic [CW-1:0] active;
  logic          ev_up, ev_dn, load_evt;

  pwm_cmp_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr(cmp_wr), .wdata(cmp_wdata),
    .shadow_en(shadow_en), .load_evt(load_evt), .active(active)
  );

  pwm_aq_events #(.CW(CW)) u_events (
    .clk(clk), .rst(rst), .cnt(cnt), .active(active),
    .cnt_zero(cnt_zero), .cnt_up(cnt_up), .load_sel(load_sel),
    .ev_up(ev_up), .ev_dn(ev_dn), .load_evt(load_evt)
  );

  pwm_aq_output u_out (
    .clk(clk), .rst(rst), .cnt_zero(cnt_zero), .ev_up(ev_up), .ev_dn(ev_dn),
    .act_zero(act_zero), .act_cmp_up(act_cmp_up), .act_cmp_dn(act_cmp_dn),
    .pwm(pwm_raw)
  );

  // R1: output low during and right after reset
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !pwm_raw);
endmodule

// File: tb/pwm_cmp_aq_bench.sv
module pwm_cmp_aq_bench;
  localparam int CW = 16;
  localparam logic [1:0] A_NONE = 2'b00, A_CLR = 2'b01, A_SET = 2'b10, A_TOG = 2'b11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt = '1;
  logic          cnt_zero = 1'b0;
  logic          cnt_up = 1'b1;
  logic          cmp_wr = 1'b0;
  logic [CW-1:0] cmp_wdata = '0;
  logic          shadow_en = 1'b0;
  logic          load_sel = 1'b0;
  logic [1:0]    act_zero = A_SET;
  logic [1:0]    act_cmp_up = A_CLR;
  logic [1:0]    act_cmp_dn = A_NONE;
  logic          pwm_raw;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pwm_cmp_aq #(.CW(CW)) u_pwm_cmp_aq (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_zero(cnt_zero), .cnt_up(cnt_up),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .shadow_en(shadow_en),
    .load_sel(load_sel), .act_zero(act_zero), .act_cmp_up(act_cmp_up),
    .act_cmp_dn(act_cmp_dn), .pwm_raw(pwm_raw)
  );

  always #5ns clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1ns;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_cnt();
    cnt = '1; cnt_zero = 1'b0; cnt_up = 1'b1;
  endtask

  task automatic imm_write(input int v);
    shadow_en = 1'b0; idle_cnt();
    cmp_wr = 1'b1; cmp_wdata = CW'(v);
    tick();
    cmp_wr = 1'b0;
  endtask

  task automatic run_up(input int prd, input int wr_c, input int wr_v, output int high);
    high = 0; cnt_up = 1'b1;
    for (int c = 0; c <= prd; c++) begin
      cnt = CW'(c); cnt_zero = (c == 0);
      cmp_wr = (c == wr_c); cmp_wdata = CW'(wr_v);
      tick();
      cmp_wr = 1'b0;
      if (pwm_raw) high++;
    end
    idle_cnt();
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    chk("R1 reset pwm", pwm_raw, 0);
    act_zero = A_NONE; act_cmp_up = A_SET;
    cnt = '0; cnt_zero = 1'b0; cnt_up = 1'b1;
    tick();
    chk("R1 active compare is zero", pwm_raw, 1);
    idle_cnt(); act_zero = A_SET; act_cmp_up = A_CLR;
  endtask

  task automatic t_hold_toggle();
    idle_cnt();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10 hold without event", pwm_raw, 1);
    end
    act_zero = A_NONE; cnt_zero = 1'b1;
    tick();
    chk("R6 no-action code", pwm_raw, 1);
    act_zero = A_TOG;
    tick();
    chk("R7 toggle on zero 1", pwm_raw, 0);
    tick();
    chk("R7 toggle on zero 2", pwm_raw, 1);
    act_zero = A_CLR;
    tick();
    chk("R6 clear code", pwm_raw, 0);
    idle_cnt(); act_zero = A_SET;
  endtask

  task automatic t_priority();
    act_zero = A_SET; act_cmp_up = A_CLR;
    cnt = '0; cnt_zero = 1'b1; cnt_up = 1'b1;
    tick();
    chk("R9 zero set beats compare clear", pwm_raw, 1);
    act_zero = A_CLR; act_cmp_up = A_SET;
    tick();
    chk("R9 zero clear beats compare set", pwm_raw, 0);
    idle_cnt(); act_zero = A_SET; act_cmp_up = A_CLR;
  endtask

  task automatic t_immediate();
    int h;
    imm_write(5);
    run_up(9, -1, 0, h);
    chk("R2 immediate compare 5", h, 5);
    run_up(9, 2, 6, h);
    chk("R2 mid-period immediate write", h, 6);
  endtask

  task automatic t_shadow();
    int h;
    shadow_en = 1'b1; load_sel = 1'b0;
    run_up(9, 2, 3, h);
    chk("R3 shadow write deferred", h, 6);
    run_up(9, -1, 0, h);
    chk("R4 shadow loaded at zero", h, 3);
  endtask

  task automatic t_load_cmp();
    int h;
    shadow_en = 1'b1; load_sel = 1'b1; act_cmp_up = A_TOG;
    run_up(9, 1, 7, h);
    chk("R5 load on compare match", h, 6);
    chk("R5 end level", pwm_raw, 1);
    load_sel = 1'b0; act_cmp_up = A_CLR;
  endtask

  task automatic t_down();
    int h = 0;
    imm_write(4);
    act_zero = A_CLR; act_cmp_dn = A_SET; act_cmp_up = A_CLR;
    cnt = '1; cnt_zero = 1'b1; tick();
    cnt_up = 1'b0;
    for (int c = 9; c >= 0; c--) begin
      cnt = CW'(c); cnt_zero = (c == 0);
      tick();
      if (pwm_raw) h++;
    end
    chk("R8 down-count compare action", h, 4);
    chk("R8 zero clears after down", pwm_raw, 0);
    idle_cnt(); act_zero = A_SET; act_cmp_dn = A_NONE;
  endtask

  task automatic t_half();
    int h;
    shadow_en = 1'b1; load_sel = 1'b0; act_zero = A_SET; act_cmp_up = A_CLR;
    run_up(1200, 3, 600, h);
    run_up(1200, -1, 0, h);
    chk("R11 half duty high count", h, 600);
  endtask

  initial begin
    t_reset();
    t_hold_toggle();
    t_priority();
    t_immediate();
    t_shadow();
    t_load_cmp();
    t_down();
    t_half();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule